// File: doc/BRIEF.md
# Packet Bus Transmit Fragmenter

This block is the transmit end of a point-to-point 32-bit packet bus on the link side of a chip. An upstream stage writes packet words into an internal queue, which decouples the packet rate from the bus rate. On the first word of each packet it also gives the packet's length in bytes. The block reads the queue and drives the words onto the bus. Each bus word carries framing flags: start of packet, end of packet, error, and a 2-bit count of the bytes that are valid in the final word.

Packets leave as fragments of at most `FRAG_WORDS` words. After each fragment, the block forces `GAP_CYCLES` idle clock cycles to model transfer overhead. A packet's final word always closes a fragment. The receiver controls the flow with `bus_enable`. A word is presented as valid only while enable is high, and the word waits on the bus until it has been taken.

The remaining-byte count sets the end of a packet; upstream sends no end marker. The length is sampled on the first word of a packet. It then counts down by four for each word, and the word that finds four or fewer bytes left becomes the final word.

Top module: `pkt_tx_fragmenter`

## Requirements
- R1: After reset `bus_valid` is low and `in_ready` is high. `in_ready` goes low once the queue holds `FIFO_DEPTH` words, and a word offered while `in_ready` is low is not accepted.
- R2: Words appear on the bus in the order they were accepted, with `bus_data` equal to `in_data`, each exactly once.
- R3: `bus_sop` is 1 on the first word of a packet and 0 on every other word.
- R4: `bus_eop` is 1 on word number ceil(L/4) of a packet of L bytes (L at least 1, taken from `in_bytes` on the packet's first word) and 0 on every other word.
- R5: On an end word, `bus_mod` gives the count of unused bytes: 00 means four valid bytes, 01 three, 10 two and 11 one. It is 00 on every word that is not an end word.
- R6: `bus_err` is 1 only on an end word, and only when `in_bad` was 1 on at least one word of that packet.
- R7: A fragment holds at most `FRAG_WORDS` words, and the end word of a packet closes its fragment. With enable held high and words waiting, the words of one fragment go out on consecutive cycles.
- R8: After the last word of a fragment, at least `GAP_CYCLES` cycles pass with `bus_valid` low. With enable high and words waiting, exactly `GAP_CYCLES` cycles pass.
- R9: `bus_valid` is never 1 while `bus_enable` is 0. A word held back by low enable keeps its data and flags unchanged until it is transferred.
- R10: With `GAP_CYCLES` = 0, fragments follow one another with no idle cycle, and the framing of R3 to R6 is unchanged.
- R11: A packet of 1 to 4 bytes is sent as one word with `bus_sop` and `bus_eop` both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transfer clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Upstream offers a word |
| in_ready | output | 1 | Queue has room; a word moves when valid and ready are both high |
| in_data | input | 32 | Packet word |
| in_bytes | input | LEN_W | Packet length in bytes, read on the first word of a packet |
| in_bad | input | 1 | Marks the packet as bad; may be set on any of its words |
| bus_enable | input | 1 | Receiver allows a transfer this cycle |
| bus_valid | output | 1 | A word is transferred this cycle |
| bus_data | output | 32 | Word on the bus |
| bus_sop | output | 1 | First word of a packet |
| bus_eop | output | 1 | Last word of a packet |
| bus_err | output | 1 | Packet marked bad (end word only) |
| bus_mod | output | 2 | Unused byte count of the end word |

## Verification
The bench builds two instances that are fed the same words. The first uses `FRAG_WORDS` = 3 and `GAP_CYCLES` = 2, so packets of four or more words are split into several fragments, and the exact two-cycle gaps can be measured between cycle stamps. The second uses `FRAG_WORDS` = 2 and `GAP_CYCLES` = 0, which exercises the zero-gap path, where a fragment boundary must not cost a cycle. Both instances have a queue depth of 8. This small depth lets a prefilled burst reach the full condition and then drain back to back.

// File: rtl/tx_frag_pkg.sv
package tx_frag_pkg;

  localparam int WORD_W         = 32;
  localparam int BYTES_PER_WORD = WORD_W / 8;

  typedef struct packed {
    logic [WORD_W-1:0] data;
    logic              sop;
    logic              eop;
    logic              err;
    logic [1:0]        mod;
  } bus_word_t;

  // True when the word that sees `left` bytes still owed is the packet's last.
  function automatic logic is_final_word(input logic [31:0] left);
    return left <= 32'(BYTES_PER_WORD);
  endfunction

  // Unused byte lanes in the final word: 4 left -> 0, 1 left -> 3.
  function automatic logic [1:0] mod_for_left(input logic [31:0] left);
    if (left >= 32'(BYTES_PER_WORD)) return 2'b00;
    return 2'(32'(BYTES_PER_WORD) - left);
  endfunction

  // Bytes still owed after one more word has been sent.
  function automatic logic [31:0] left_after_word(input logic [31:0] left);
    if (left <= 32'(BYTES_PER_WORD)) return 32'd0;
    return left - 32'(BYTES_PER_WORD);
  endfunction

endpackage

// File: rtl/tx_frag_fifo.sv
module tx_frag_fifo #(
  parameter int WIDTH = 49,
  parameter int DEPTH = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push,
  input  logic [WIDTH-1:0]             wr_data,
  input  logic                         pop,
  output logic [WIDTH-1:0]             rd_data,
  output logic                         not_empty,
  output logic                         full,
  output logic [$clog2(DEPTH+1)-1:0]   count
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr;
  logic [AW-1:0]    rd_ptr;
  logic             do_push;
  logic             do_pop;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign full      = (count == CW'(DEPTH));
  assign not_empty = (count != '0);
  assign do_push   = push & ~full;
  assign do_pop    = pop & not_empty;
  assign rd_data   = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= bump(wr_ptr);
      if (do_pop)  rd_ptr <= bump(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

endmodule

// File: rtl/tx_gap_timer.sv
module tx_gap_timer #(
  parameter int GAP_CYCLES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic gap_open
);

  generate
    if (GAP_CYCLES == 0) begin : g_no_gap
      assign gap_open = 1'b1;
    end else begin : g_count
      localparam int GW = $clog2(GAP_CYCLES + 1);
      logic [GW-1:0] remain;

      // A load on the edge that follows the cycle where remain is 1 gives
      // exactly GAP_CYCLES empty bus cycles after the closing word.
      assign gap_open = (remain <= GW'(1)) & ~start;

      always_ff @(posedge clk) begin
        if (!rst_n)              remain <= '0;
        else if (start)          remain <= GW'(GAP_CYCLES);
        else if (remain != '0)   remain <= remain - GW'(1);
      end
    end
  endgenerate

endmodule

// File: rtl/tx_frag_ctrl.sv
module tx_frag_ctrl
  import tx_frag_pkg::*;
#(
  parameter int FRAG_WORDS = 4,
  parameter int LEN_W      = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              head_valid,
  input  logic [WORD_W-1:0] head_data,
  input  logic [LEN_W-1:0]  head_bytes,
  input  logic              head_bad,
  input  logic              gap_open,
  input  logic              bus_enable,
  output logic              head_pop,
  output bus_word_t         word_q,
  output logic              word_pending,
  output logic              word_xfer,
  output logic              frag_end_xfer
);

  localparam int IDX_W = (FRAG_WORDS > 1) ? $clog2(FRAG_WORDS) : 1;

  logic             in_pkt_q;
  logic [LEN_W-1:0] left_q;
  logic             bad_acc_q;
  logic [IDX_W-1:0] idx_q;
  logic             frag_last_q;

  logic [LEN_W-1:0] cur_left;
  logic             cur_final;
  logic             cur_bad;
  logic             cur_frag_last;
  logic             slot_free;
  bus_word_t        next_word;

  always_comb begin
    cur_left       = in_pkt_q ? left_q : head_bytes;
    cur_final      = is_final_word(32'(cur_left));
    cur_bad        = (in_pkt_q & bad_acc_q) | head_bad;
    cur_frag_last  = cur_final | (idx_q == IDX_W'(FRAG_WORDS - 1));
    next_word.data = head_data;
    next_word.sop  = ~in_pkt_q;
    next_word.eop  = cur_final;
    next_word.err  = cur_final & cur_bad;
    next_word.mod  = cur_final ? mod_for_left(32'(cur_left)) : 2'b00;
  end

  assign word_xfer     = word_pending & bus_enable;
  assign slot_free     = ~word_pending | word_xfer;
  assign head_pop      = slot_free & head_valid & gap_open;
  assign frag_end_xfer = word_xfer & frag_last_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word_q       <= '0;
      word_pending <= 1'b0;
      frag_last_q  <= 1'b0;
      in_pkt_q     <= 1'b0;
      left_q       <= '0;
      bad_acc_q    <= 1'b0;
      idx_q        <= '0;
    end else if (head_pop) begin
      word_q       <= next_word;
      word_pending <= 1'b1;
      frag_last_q  <= cur_frag_last;
      in_pkt_q     <= ~cur_final;
      left_q       <= LEN_W'(left_after_word(32'(cur_left)));
      bad_acc_q    <= cur_bad & ~cur_final;
      idx_q        <= cur_frag_last ? '0 : idx_q + IDX_W'(1);
    end else if (word_xfer) begin
      word_pending <= 1'b0;
    end
  end

endmodule

// File: rtl/pkt_tx_fragmenter.sv
module pkt_tx_fragmenter
  import tx_frag_pkg::*;
#(
  parameter int FRAG_WORDS = 4,
  parameter int GAP_CYCLES = 2,
  parameter int FIFO_DEPTH = 8,
  parameter int LEN_W      = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [31:0]       in_data,
  input  logic [LEN_W-1:0]  in_bytes,
  input  logic              in_bad,
  input  logic              bus_enable,
  output logic              bus_valid,
  output logic [31:0]       bus_data,
  output logic              bus_sop,
  output logic              bus_eop,
  output logic              bus_err,
  output logic [1:0]        bus_mod
);

  localparam int ENTRY_W = WORD_W + LEN_W + 1;
  localparam int CNT_W   = $clog2(FIFO_DEPTH + 1);

  // Named internal events, also observed by the bound checker.
  logic [CNT_W-1:0]   fifo_count;
  logic               fifo_full;
  logic               head_valid;
  logic               head_pop;
  logic               word_pending;
  logic               word_xfer;
  logic               frag_end_xfer;
  logic               gap_open;
  logic [ENTRY_W-1:0] head_entry;
  bus_word_t          word_q;

  assign in_ready = ~fifo_full;

  tx_frag_fifo #(
    .WIDTH (ENTRY_W),
    .DEPTH (FIFO_DEPTH)
  ) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (in_valid & in_ready),
    .wr_data   ({in_data, in_bytes, in_bad}),
    .pop       (head_pop),
    .rd_data   (head_entry),
    .not_empty (head_valid),
    .full      (fifo_full),
    .count     (fifo_count)
  );

  tx_gap_timer #(
    .GAP_CYCLES (GAP_CYCLES)
  ) u_gap (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (frag_end_xfer),
    .gap_open (gap_open)
  );

  tx_frag_ctrl #(
    .FRAG_WORDS (FRAG_WORDS),
    .LEN_W      (LEN_W)
  ) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .head_valid    (head_valid),
    .head_data     (head_entry[ENTRY_W-1 -: WORD_W]),
    .head_bytes    (head_entry[LEN_W:1]),
    .head_bad      (head_entry[0]),
    .gap_open      (gap_open),
    .bus_enable    (bus_enable),
    .head_pop      (head_pop),
    .word_q        (word_q),
    .word_pending  (word_pending),
    .word_xfer     (word_xfer),
    .frag_end_xfer (frag_end_xfer)
  );

  assign bus_valid = word_xfer;
  assign bus_data  = word_q.data;
  assign bus_sop   = word_q.sop;
  assign bus_eop   = word_q.eop;
  assign bus_err   = word_q.err;
  assign bus_mod   = word_q.mod;

endmodule

// File: rtl/tx_frag_checker.sv
module tx_frag_checker #(
  parameter int FRAG_WORDS = 4,
  parameter int GAP_CYCLES = 2,
  parameter int FIFO_DEPTH = 8
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           in_valid,
  input logic                           in_ready,
  input logic                           bus_enable,
  input logic                           bus_valid,
  input logic [31:0]                    bus_data,
  input logic                           bus_sop,
  input logic                           bus_eop,
  input logic                           bus_err,
  input logic [1:0]                     bus_mod,
  input logic                           word_pending,
  input logic                           frag_end_xfer,
  input logic [$clog2(FIFO_DEPTH+1)-1:0] fifo_count
);

  localparam int CNT_W = $clog2(FIFO_DEPTH + 1);
  localparam int FW    = $clog2(FRAG_WORDS + 1);
  localparam int IW    = $clog2(GAP_CYCLES + 2);

  logic          mid_pkt;
  logic [FW-1:0] frag_words;
  logic          gap_armed;
  logic [IW-1:0] idle_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)         mid_pkt <= 1'b0;
    else if (bus_valid) mid_pkt <= ~bus_eop;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)             frag_words <= '0;
    else if (frag_end_xfer) frag_words <= '0;
    else if (bus_valid)     frag_words <= frag_words + FW'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap_armed <= 1'b0;
      idle_cnt  <= '0;
    end else if (frag_end_xfer) begin
      gap_armed <= 1'b1;
      idle_cnt  <= '0;
    end else if (bus_valid) begin
      gap_armed <= 1'b0;
    end else if (gap_armed && idle_cnt < IW'(GAP_CYCLES)) begin
      idle_cnt  <= idle_cnt + IW'(1);
    end
  end

  a_r1_no_write_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready) |=> (fifo_count <= $past(fifo_count)));

  a_r1_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_count <= CNT_W'(FIFO_DEPTH));

  a_r3_sop_marks_first: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> (bus_sop == !mid_pkt));

  a_r5_mod_zero_mid: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_eop) |-> (bus_mod == 2'b00));

  a_r6_err_on_end: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_err) |-> bus_eop);

  a_r7_frag_bound: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> (frag_words < FW'(FRAG_WORDS)));

  a_r7_eop_closes_frag: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_eop) |-> frag_end_xfer);

  a_r8_gap_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && gap_armed) |-> (idle_cnt >= IW'(GAP_CYCLES)));

  a_r9_word_held: assert property (@(posedge clk) disable iff (!rst_n)
    (word_pending && !bus_enable) |=>
      (word_pending && $stable(bus_data) && $stable(bus_sop) &&
       $stable(bus_eop) && $stable(bus_err) && $stable(bus_mod)));

endmodule

bind pkt_tx_fragmenter tx_frag_checker #(
  .FRAG_WORDS (FRAG_WORDS),
  .GAP_CYCLES (GAP_CYCLES),
  .FIFO_DEPTH (FIFO_DEPTH)
) u_tx_frag_checker (
  .clk           (clk),
  .rst_n         (rst_n),
  .in_valid      (in_valid),
  .in_ready      (in_ready),
  .bus_enable    (bus_enable),
  .bus_valid     (bus_valid),
  .bus_data      (bus_data),
  .bus_sop       (bus_sop),
  .bus_eop       (bus_eop),
  .bus_err       (bus_err),
  .bus_mod       (bus_mod),
  .word_pending  (word_pending),
  .frag_end_xfer (frag_end_xfer),
  .fifo_count    (fifo_count)
);

// File: tb/test_pkt_tx_fragmenter.sv
module test_pkt_tx_fragmenter;

  localparam int A_FRAG = 3;
  localparam int A_GAP  = 2;
  localparam int B_FRAG = 2;
  localparam int B_GAP  = 0;
  localparam int DEPTH  = 8;
  localparam int LW     = 16;
  localparam int MAXW   = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_enable = 1'b0;
  logic drv_valid = 1'b0;
  logic [31:0] drv_data = '0;
  logic [LW-1:0] drv_bytes = '0;
  logic drv_bad = 1'b0;

  logic rdy_a, rdy_b, both_ready, in_valid;
  logic a_valid, a_sop, a_eop, a_err, b_valid, b_sop, b_eop, b_err;
  logic [31:0] a_data, b_data;
  logic [1:0] a_mod, b_mod;

  assign both_ready = rdy_a & rdy_b;
  assign in_valid   = drv_valid & both_ready;

  pkt_tx_fragmenter #(.FRAG_WORDS(A_FRAG), .GAP_CYCLES(A_GAP), .FIFO_DEPTH(DEPTH), .LEN_W(LW))
  i_pkt_tx_fragmenter (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy_a),
    .in_data(drv_data), .in_bytes(drv_bytes), .in_bad(drv_bad), .bus_enable(bus_enable),
    .bus_valid(a_valid), .bus_data(a_data), .bus_sop(a_sop), .bus_eop(a_eop),
    .bus_err(a_err), .bus_mod(a_mod));

  pkt_tx_fragmenter #(.FRAG_WORDS(B_FRAG), .GAP_CYCLES(B_GAP), .FIFO_DEPTH(DEPTH), .LEN_W(LW))
  i_pkt_tx_fragmenter_nogap (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy_b),
    .in_data(drv_data), .in_bytes(drv_bytes), .in_bad(drv_bad), .bus_enable(bus_enable),
    .bus_valid(b_valid), .bus_data(b_data), .bus_sop(b_sop), .bus_eop(b_eop),
    .bus_err(b_err), .bus_mod(b_mod));

  always #4 clk = ~clk;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;
  int en_viol = 0;

  // Packed record: {data, sop, eop, err, mod}
  logic [36:0] ex_w [MAXW];
  int          ex_idx [MAXW];
  int          ex_n = 0;
  logic [36:0] oa_w [MAXW];
  int          oa_cyc [MAXW];
  int          na = 0;
  logic [36:0] ob_w [MAXW];
  int          ob_cyc [MAXW];
  int          nb = 0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n) begin
      if (a_valid) begin
        if (na < MAXW) begin
          oa_w[na]   = {a_data, a_sop, a_eop, a_err, a_mod};
          oa_cyc[na] = cyc;
        end
        na = na + 1;
      end
      if (b_valid) begin
        if (nb < MAXW) begin
          ob_w[nb]   = {b_data, b_sop, b_eop, b_err, b_mod};
          ob_cyc[nb] = cyc;
        end
        nb = nb + 1;
      end
      if ((a_valid || b_valid) && !bus_enable) en_viol = en_viol + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  task automatic clear_records();
    ex_n = 0; na = 0; nb = 0; en_viol = 0;
  endtask

  // Called just after a negedge; returns just after the negedge following acceptance.
  task automatic push_word(input logic [31:0] d, input logic [LW-1:0] nbytes, input logic bad);
    bit took;
    drv_data = d; drv_bytes = nbytes; drv_bad = bad; drv_valid = 1'b1;
    took = 1'b0;
    while (!took) begin
      took = both_ready;
      @(negedge clk);
    end
    drv_valid = 1'b0;
  endtask

  task automatic add_packet(input int len, input int bad_w, input int tag);
    int nw, rem;
    logic [1:0] emod;
    nw  = (len + 3) / 4;
    rem = len % 4;
    emod = (rem == 0) ? 2'd0 : 2'(4 - rem);
    for (int w = 0; w < nw; w++) begin
      logic [31:0] d;
      bit last;
      d = {8'(tag), 8'(w), 16'hC3A5 ^ 16'(w * 37)};
      last = (w == nw - 1);
      ex_w[ex_n]   = {d, (w == 0), last, last && (bad_w >= 0), last ? emod : 2'd0};
      ex_idx[ex_n] = w;
      ex_n++;
      push_word(d, LW'(len), (w == bad_w));
    end
  endtask

  task automatic wait_drain();
    for (int k = 0; k < 3000; k++) begin
      if (na >= ex_n && nb >= ex_n) break;
      @(negedge clk);
    end
    repeat (8) @(negedge clk);
    chk(na == ex_n, "R2", "word count A", na, ex_n);
    chk(nb == ex_n, "R2", "word count B", nb, ex_n);
  endtask

  task automatic check_word(input string inst, input logic [36:0] got, input logic [36:0] exp);
    chk(got[36:5] == exp[36:5], "R2", {inst, " data"}, got[36:5], exp[36:5]);
    chk(got[4] == exp[4], "R3", {inst, " sop"}, got[4], exp[4]);
    chk(got[3] == exp[3], "R4", {inst, " eop"}, got[3], exp[3]);
    chk(got[1:0] == exp[1:0], "R5", {inst, " mod"}, got[1:0], exp[1:0]);
    chk(got[2] == exp[2], "R6", {inst, " err"}, got[2], exp[2]);
    if (exp[4] && exp[3])
      chk(got[4] && got[3], "R11", {inst, " single word sop+eop"}, {got[4], got[3]}, 3);
  endtask

  task automatic compare_all(input bit exact_a, input bit exact_b);
    for (int i = 0; i < ex_n && i < na && i < nb && i < MAXW; i++) begin
      check_word("A", oa_w[i], ex_w[i]);
      check_word("B", ob_w[i], ex_w[i]);
    end
    for (int i = 0; i + 1 < ex_n && i + 1 < na && i + 1 < MAXW; i++) begin
      bit fe;
      int dt;
      fe = ex_w[i][3] || (ex_idx[i] % A_FRAG == A_FRAG - 1);
      dt = oa_cyc[i+1] - oa_cyc[i];
      if (exact_a) begin
        if (fe) chk(dt == A_GAP + 1, "R8", "A spacing after fragment", dt, A_GAP + 1);
        else    chk(dt == 1, "R7", "A spacing inside fragment", dt, 1);
      end else if (fe) begin
        chk(dt >= A_GAP + 1, "R8", "A minimum gap", dt, A_GAP + 1);
      end
    end
    if (exact_b)
      for (int i = 0; i + 1 < ex_n && i + 1 < nb && i + 1 < MAXW; i++)
        chk(ob_cyc[i+1] - ob_cyc[i] == 1, "R10", "B zero-gap spacing",
            ob_cyc[i+1] - ob_cyc[i], 1);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; bus_enable = 1'b0; drv_valid = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(a_valid == 1'b0, "R1", "A valid after reset", a_valid, 0);
    chk(b_valid == 1'b0, "R1", "B valid after reset", b_valid, 0);
    chk(rdy_a == 1'b1, "R1", "A ready after reset", rdy_a, 1);
    chk(rdy_b == 1'b1, "R1", "B ready after reset", rdy_b, 1);
  endtask

  // Mixed lengths, enable high: framing, fragment cuts and exact gaps on A.
  task automatic t_stream();
    clear_records();
    bus_enable = 1'b1;
    add_packet(1, -1, 1);
    add_packet(4, 0, 2);
    add_packet(5, 0, 3);
    add_packet(12, -1, 4);
    add_packet(13, 3, 5);
    add_packet(7, -1, 6);
    add_packet(2, -1, 7);
    wait_drain();
    compare_all(1'b1, 1'b0);
  endtask

  // Queue filled with enable low, then released: full flag, holding, back-to-back drain.
  task automatic t_burst();
    clear_records();
    bus_enable = 1'b0;
    add_packet(36, 4, 8);
    chk(rdy_a == 1'b0, "R1", "A ready when full", rdy_a, 0);
    chk(rdy_b == 1'b0, "R1", "B ready when full", rdy_b, 0);
    drv_data = 32'hDEAD_0001; drv_bytes = LW'(4); drv_bad = 1'b0; drv_valid = 1'b1;
    repeat (4) @(negedge clk);
    drv_valid = 1'b0;
    chk(na == 0, "R9", "A words while enable low", na, 0);
    chk(nb == 0, "R9", "B words while enable low", nb, 0);
    bus_enable = 1'b1;
    wait_drain();
    compare_all(1'b1, 1'b1);
  endtask

  // Enable toggled while packets stream in.
  task automatic t_enable_stall();
    clear_records();
    bus_enable = 1'b0;
    fork
      begin
        add_packet(30, -1, 9);
        add_packet(6, 1, 10);
        add_packet(3, -1, 11);
      end
      begin
        for (int k = 0; k < 60; k++) begin
          bus_enable = ((k % 5) >= 2);
          @(negedge clk);
        end
        bus_enable = 1'b1;
      end
    join
    wait_drain();
    chk(en_viol == 0, "R9", "valid while enable low", en_viol, 0);
    compare_all(1'b0, 1'b0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL R2 watchdog: got %0d cycles expected completion", cyc);
    summary();
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_stream();
    t_burst();
    t_enable_stall();
    summary();
    $finish;
  end

endmodule